// File: doc/BRIEF.md
# Serial Bit-Rate Timing Generator

This block derives every timing strobe a serial port needs from the system clock and a 12-bit divider setting. A reloading down-counter produces a base strobe once every (divider + 1) clock cycles. From that strobe the block makes three outputs: a one-cycle transmit bit enable, a one-cycle receive oversampling enable, and a square-wave clock for a synchronous link.

Two pins pick the operating style. With `mode_sync` low the link is asynchronous. The receive enable then fires on every base strobe. The transmit enable fires once every 16 base strobes, or once every 8 when `dbl_speed` is high. With `mode_sync` high the block drives `sclk_out` as a master clock, toggling it on every base strobe, and `dbl_speed` has no effect. All pins are plain control and timing signals. No data passes through the block, so it has no valid/ready handshake.

Top module: `baud_gen_top`

## Requirements
- R1: While `rst` is high, `tx_bit_en`, `rx_os_en` and `sclk_out` are all 0. The first clock edge with `rst` high clears the counters and forces `sclk_out` low.
- R2: In asynchronous mode, with `div_val` = N held steady, `rx_os_en` pulses for one cycle every N+1 cycles.
- R3: In asynchronous mode with `dbl_speed` = 0, `tx_bit_en` pulses once every 16·(N+1) cycles.
- R4: In asynchronous mode with `dbl_speed` = 1, `tx_bit_en` pulses once every 8·(N+1) cycles. `rx_os_en` keeps its period of N+1, which gives 8 receive samples per bit instead of 16.
- R5: In synchronous mode, `sclk_out` has a period of 2·(N+1) cycles and stays high for exactly N+1 cycles of each period.
- R6: In synchronous mode, `dbl_speed` is ignored. All periods are the same whether it is 0 or 1.
- R7: In asynchronous mode, `sclk_out` stays low.
- R8: A new value on `div_val` takes effect at once. When N' is applied before a clock edge, the next `rx_os_en` pulse is observed after exactly N'+1 edges, with no pulse before it, whatever count remained from the old value.
- R9: With `div_val` = 0 in asynchronous mode, `rx_os_en` is high on every cycle.
- R10: The full 12-bit range applies. With `div_val` = 4095, the `rx_os_en` period is 4096 cycles.
- R11: In synchronous mode, `tx_bit_en` pulses in the cycle before `sclk_out` falls, so `sclk_out` reads 1 at the pulse. `rx_os_en` pulses in the cycle before `sclk_out` rises, so `sclk_out` reads 0 at the pulse. The two are never high together. In this mode both have a period of 2·(N+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_val | input | 12 | Divider setting N; base strobe every N+1 cycles |
| dbl_speed | input | 1 | Halves the asynchronous bit period; ignored in synchronous mode |
| mode_sync | input | 1 | 0 = asynchronous, 1 = synchronous master |
| tx_bit_en | output | 1 | One-cycle transmit bit enable |
| rx_os_en | output | 1 | One-cycle receive sampling enable |
| sclk_out | output | 1 | Synchronous master clock; low in asynchronous mode |

## Verification
The bench builds the block with its defaults: a 12-bit divider and an oversampling ratio of 16, so double speed uses a ratio of 8. These widths let it reach both ends of the divider range. It uses 0, where the strobe fires every cycle and the synchronous clock toggles every cycle, and 4095, where the counter must use all twelve bits. At those same widths it also exercises a jump from a large divider to a small one in the middle of a count, and random mixes of divider, mode and speed.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    LINK_ASYNC = 1'b0,
    LINK_SYNC  = 1'b1
  } link_mode_e;

  // Bit period in base strobes for a given mode and speed.
  function automatic int unsigned strobes_per_bit(input link_mode_e m,
                                                  input logic dbl,
                                                  input int unsigned os_ratio);
    if (m == LINK_SYNC) return 2;
    return dbl ? (os_ratio / 2) : os_ratio;
  endfunction
endpackage

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             div_chg;

  assign div_chg = (div_val != div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= div_val;
    end else if (div_chg) begin
      cnt_q <= div_val;
      div_q <= div_val;
    end else if (cnt_q == '0) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = !rst && !div_chg && (cnt_q == '0);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_q);

  // R2
  reload_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == $past(div_q)));

  // R8
  new_div_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    div_chg |=> (cnt_q == $past(div_val)));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int OS_RATIO = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  link_mode_e mode,
  input  logic       dbl_speed,
  output logic       tx_en,
  output logic       rx_en
);
  localparam int PSC_W = $clog2(OS_RATIO);
  localparam int DBL_RATIO = OS_RATIO / 2;
  localparam logic [PSC_W-1:0] LAST_NORM = PSC_W'(OS_RATIO - 1);
  localparam logic [PSC_W-1:0] LAST_DBL  = PSC_W'(DBL_RATIO - 1);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] last;
  logic [1:0]       cfg, cfg_q;
  logic             cfg_chg;
  logic             active;
  logic             wrap;

  assign cfg     = {mode == LINK_SYNC, dbl_speed};
  assign cfg_chg = (cfg != cfg_q);
  assign last    = dbl_speed ? LAST_DBL : LAST_NORM;
  assign active  = tick && (mode == LINK_ASYNC) && !cfg_chg;
  assign wrap    = (psc_q >= last);

  always_ff @(posedge clk) begin
    if (rst || cfg_chg) begin
      psc_q <= '0;
      cfg_q <= cfg;
    end else if (active) begin
      psc_q <= wrap ? '0 : psc_q + 1'b1;
    end
  end

  assign rx_en = active;
  assign tx_en = active && wrap;

  // R4
  dbl_psc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[1] && cfg_q[0]) |-> (psc_q < PSC_W'(DBL_RATIO)));

  // R3
  tx_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> (psc_q == '0));

  // R1
  psc_reset_chk: assert property (@(posedge clk)
    rst |=> (psc_q == '0));
endmodule

// File: rtl/baud_sync_clk.sv
module baud_sync_clk
  import baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  link_mode_e mode,
  output logic       sclk,
  output logic       tx_en,
  output logic       rx_en
);
  logic sclk_q;
  logic on;

  assign on = (mode == LINK_SYNC);

  always_ff @(posedge clk) begin
    if (rst || !on) sclk_q <= 1'b0;
    else if (tick)  sclk_q <= ~sclk_q;
  end

  assign sclk  = sclk_q;
  assign tx_en = on && tick && sclk_q;
  assign rx_en = on && tick && !sclk_q;

  // R7
  sclk_idle_async_chk: assert property (@(posedge clk) disable iff (rst)
    !on |=> !sclk_q);

  // R5
  sclk_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    (on && tick) |=> (sclk_q != $past(sclk_q)));

  // R5
  sclk_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (on && !tick) |=> $stable(sclk_q));
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int OS_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             dbl_speed,
  input  logic             mode_sync,
  output logic             tx_bit_en,
  output logic             rx_os_en,
  output logic             sclk_out
);
  link_mode_e mode;
  logic       base_tick;
  logic       a_tx, a_rx, s_tx, s_rx;

  assign mode = mode_sync ? LINK_SYNC : LINK_ASYNC;

  baud_down_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .div_val(div_val), .tick(base_tick)
  );

  baud_prescaler #(.OS_RATIO(OS_RATIO)) u_psc (
    .clk(clk), .rst(rst), .tick(base_tick), .mode(mode),
    .dbl_speed(dbl_speed), .tx_en(a_tx), .rx_en(a_rx)
  );

  baud_sync_clk u_sclk (
    .clk(clk), .rst(rst), .tick(base_tick), .mode(mode),
    .sclk(sclk_out), .tx_en(s_tx), .rx_en(s_rx)
  );

  assign tx_bit_en = a_tx | s_tx;
  assign rx_os_en  = a_rx | s_rx;

  // R11
  sync_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sync |-> !(tx_bit_en && rx_os_en));

  // R11
  sync_tx_at_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sync && tx_bit_en) |=> !sclk_out);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!tx_bit_en && !rx_os_en));

  // R1
  reset_sclk_low_chk: assert property (@(posedge clk)
    rst |=> !sclk_out);
endmodule

// File: tb/test_baud_gen_top.sv
module test_baud_gen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] div_val = 12'd0;
  logic        dbl_speed = 1'b0;
  logic        mode_sync = 1'b0;
  logic        tx_bit_en, rx_os_en, sclk_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  baud_gen_top i_baud_gen_top (
    .clk(clk), .rst(rst), .div_val(div_val), .dbl_speed(dbl_speed),
    .mode_sync(mode_sync), .tx_bit_en(tx_bit_en), .rx_os_en(rx_os_en),
    .sclk_out(sclk_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_tx(input int n, input bit s, input bit d);
    if (s) return 2 * (n + 1);
    return d ? 8 * (n + 1) : 16 * (n + 1);
  endfunction

  function automatic int exp_rx(input int n, input bit s);
    return s ? 2 * (n + 1) : (n + 1);
  endfunction

  function automatic bit sig(input int which);
    case (which)
      0: return tx_bit_en;
      1: return rx_os_en;
      default: return sclk_out;
    endcase
  endfunction

  // Wait for a pulse, then count cycles until the next one.
  task automatic period(input int which, output int p);
    int w = 0;
    do begin @(negedge clk); w++; end while (!sig(which) && w < 70000);
    p = 0;
    do begin @(negedge clk); p++; end while (!sig(which) && p < 70000);
  endtask

  task automatic apply(input int n, input bit s, input bit d);
    @(negedge clk);
    div_val = 12'(n); mode_sync = s; dbl_speed = d;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p, h;
    int unsigned seed;
    seed = $urandom(32'd4242);

    // R1: outputs quiet during reset
    div_val = 12'd5;
    repeat (4) begin
      @(negedge clk);
      chk("R1 tx", tx_bit_en, 0);
      chk("R1 rx", rx_os_en, 0);
      chk("R1 sclk", sclk_out, 0);
    end
    rst = 0;

    // R2, R3: async normal
    apply(5, 0, 0);
    period(1, p); chk("R2 rx period", p, exp_rx(5, 0));
    period(0, p); chk("R3 tx period", p, exp_tx(5, 0, 0));
    // R7
    chk("R7 sclk low", sclk_out, 0);

    // R4: double speed
    apply(5, 0, 1);
    period(0, p); chk("R4 tx period", p, exp_tx(5, 0, 1));
    period(1, p); chk("R4 rx period", p, exp_rx(5, 0));

    // R5, R6, R11: sync
    for (int d = 0; d < 2; d++) begin
      apply(4, 1, d[0]);
      period(0, p); chk("R6 sync tx period", p, exp_tx(4, 1, d[0]));
      chk("R11 sclk high at tx", sclk_out, 1);
      period(1, p); chk("R11 sync rx period", p, exp_rx(4, 1));
      chk("R11 sclk low at rx", sclk_out, 0);
      while (sclk_out) @(negedge clk);
      while (!sclk_out) @(negedge clk);
      h = 0;
      while (sclk_out && h < 10000) begin h++; @(negedge clk); end
      chk("R5 sclk high time", h, 5);
    end

    // R9: divider 0
    apply(0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R9 rx every cycle", rx_os_en, 1);
    end
    period(0, p); chk("R9 tx period", p, 16);
    apply(0, 1, 0);
    period(0, p); chk("R5 sync period at 0", p, 2);

    // R8: change mid-count from large to small
    apply(300, 0, 0);
    period(1, p);
    repeat (20) @(negedge clk);
    div_val = 12'd3;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R8 immediate reload", rx_os_en, (i == 4) ? 1 : 0);
    end

    // R10: full range
    apply(4095, 0, 0);
    period(1, p); chk("R10 rx period max", p, 4096);

    // random mix
    for (int t = 0; t < 12; t++) begin
      int n; bit s, d;
      n = int'($urandom_range(0, 40));
      s = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      apply(n, s, d);
      period(0, p);
      chk(s ? "R6 rand tx" : (d ? "R4 rand tx" : "R3 rand tx"), p, exp_tx(n, s, d));
      period(1, p);
      chk(s ? "R11 rand rx" : "R2 rand rx", p, exp_rx(n, s));
    end

    // R1: reset mid-run
    apply(2, 1, 0);
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk("R1 sclk after reset", sclk_out, 0);
    chk("R1 rx in reset", rx_os_en, 0);
    rst = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule